// File: doc/BRIEF.md
# Lost Sample Detector and Substitutor

This block sits behind a sample alignment stage in a protection data path. Each aligned sample arrives with three status bits. The first tells whether the sample arrived within the allowed delay. The second marks it as quality-invalid. The third tells whether its source was time-synchronized. The block judges every sample as good or lost. A good sample passes through unchanged. A lost sample is replaced by a substitute value, so that the filters further down the path keep running instead of blocking.

A two-bit mode input chooses the substitution policy:
- zero,
- the last good value,
- the next good value,
- the mean of the neighbouring good values.

The last two policies need to see the sample that follows a lost one. For this reason the block always holds one sample of look-ahead. Every sample leaves the block only after its successor has been accepted, whatever the mode, so the latency never depends on the mode.

Both sides are valid/ready streams. Each output sample carries a flag that marks substitution. A saturating counter reports how many substituted samples have been emitted.

Top module: `smp_gap_fill`

## Requirements
- R1: A sample with `in_present_i` = 0 (it did not arrive within the allowed delay) is lost.
- R2: A sample with `in_qual_bad_i` = 1 (its quality is invalid) is lost.
- R3: A sample with `in_sync_i` = 0 (its source is not synchronized) is lost.
- R4: A good sample (present 1, quality-bad 0, sync 1) is emitted with its own value and `out_subst_o` = 0.
- R5: With `mode_i` = 0, a lost sample is emitted as 0 with `out_subst_o` = 1.
- R6: With `mode_i` = 1, a lost sample is emitted as the last good value before it. If no good sample has been emitted since reset, it is emitted as 0. `out_subst_o` is 1.
- R7: With `mode_i` = 2, a lost sample is emitted as the value of the sample that follows it, if that sample is good. Otherwise the R6 fallback applies. `out_subst_o` is 1.
- R8: With `mode_i` = 3, a lost sample that has a good previous value and a good following sample is emitted as (prev + next) >>> 1. This is a signed, one-bit-wider sum with an arithmetic shift, so it rounds toward minus infinity. If the following sample is lost, the R6 fallback applies. If there is no good previous value, the output is 0. `out_subst_o` is 1.
- R9: A sample is emitted only after the next sample has been accepted. It appears on the output in the cycle after that accept, and samples leave in arrival order. `mode_i` is sampled at that accept.
- R10: While `out_valid_o` = 1 and `out_ready_i` = 0, the output sample and its flag stay unchanged, and `in_ready_o` is 0.
- R11: `subst_cnt_o` increments by one for each emitted sample with `out_subst_o` = 1. It saturates at 2^CNT_W-1.
- R12: After reset, `out_valid_o` = 0, `subst_cnt_o` = 0, `in_ready_o` = 1, and no held or good sample is remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Input sample accepted when high together with valid |
| in_data_i | input | DATA_W | Signed sample value |
| in_present_i | input | 1 | 1 = arrived within the delay budget |
| in_qual_bad_i | input | 1 | 1 = quality invalid |
| in_sync_i | input | 1 | 1 = source synchronized |
| mode_i | input | 2 | Substitution policy: 0 zero, 1 last good, 2 next good, 3 mean |
| out_valid_o | output | 1 | Output sample valid |
| out_ready_i | input | 1 | Downstream accepts the output sample |
| out_data_o | output | DATA_W | Signed output value |
| out_subst_o | output | 1 | 1 = value is a substitute |
| subst_cnt_o | output | CNT_W | Saturating count of substituted samples emitted |

## Verification
The main check is a stream of mixed good and lost samples. The cause of loss rotates among the three status bits, and the mode switches from sample to sample. This shows whether each cause on its own marks a sample lost, and whether each policy picks the right neighbour.

Lost samples are also sent in runs of two. In that case the next-value and mean policies must fall back to the last good value rather than use a lost neighbour. Negative neighbours with an odd sum show that the mean uses the signed sum with floor rounding.

Directed sequences right after reset cover the case where no good value exists yet. A stalled output shows that data is held and input is blocked. A long run of losses drives the counter into saturation.

// File: rtl/gap_pkg.sv
package gap_pkg;
  typedef enum logic [1:0] {
    SUB_ZERO   = 2'd0,
    SUB_HOLD   = 2'd1,
    SUB_NEXT   = 2'd2,
    SUB_INTERP = 2'd3
  } sub_mode_e;
endpackage

// File: rtl/gap_classify.sv
module gap_classify (
  input  logic present_i,
  input  logic qual_bad_i,
  input  logic sync_i,
  output logic lost_o
);
  // any single cause is enough (R1, R2, R3)
  always_comb lost_o = !present_i || qual_bad_i || !sync_i;
endmodule

// File: rtl/gap_select.sv
module gap_select
  import gap_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  sub_mode_e          mode_i,
  input  logic [DATA_W-1:0]  cur_data_i,
  input  logic               cur_lost_i,
  input  logic [DATA_W-1:0]  prev_data_i,
  input  logic               prev_ok_i,
  input  logic [DATA_W-1:0]  next_data_i,
  input  logic               next_lost_i,
  output logic [DATA_W-1:0]  data_o,
  output logic               subst_o
);
  localparam int unsigned SUM_W = DATA_W + 1;

  logic signed [SUM_W-1:0]  sum;
  logic        [DATA_W-1:0] mean;
  logic        [DATA_W-1:0] fallback;
  logic        [DATA_W-1:0] repl;

  always_comb begin
    sum      = $signed({prev_data_i[DATA_W-1], prev_data_i})
             + $signed({next_data_i[DATA_W-1], next_data_i});
    mean     = DATA_W'(sum >>> 1);
    fallback = prev_ok_i ? prev_data_i : '0;
  end

  always_comb begin
    case (mode_i)
      SUB_ZERO:   repl = '0;
      SUB_HOLD:   repl = fallback;
      SUB_NEXT:   repl = next_lost_i ? fallback : next_data_i;
      SUB_INTERP: repl = next_lost_i ? fallback : (prev_ok_i ? mean : '0);
      default:    repl = '0;
    endcase
  end

  always_comb begin
    subst_o = cur_lost_i;
    data_o  = cur_lost_i ? repl : cur_data_i;
  end
endmodule

// File: rtl/gap_sat_cnt.sv
module gap_sat_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_cnt_sat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == CNT_MAX |=> cnt_q == CNT_MAX);

  p_cnt_inc_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && cnt_q != CNT_MAX |=> cnt_q == $past(cnt_q) + 1'b1);

  p_cnt_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/smp_gap_fill.sv
module smp_gap_fill
  import gap_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_present_i,
  input  logic              in_qual_bad_i,
  input  logic              in_sync_i,
  input  logic [1:0]        mode_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_subst_o,
  output logic [CNT_W-1:0]  subst_cnt_o
);
  // look-ahead slot
  logic              hold_v_q;
  logic [DATA_W-1:0] hold_data_q;
  logic              hold_lost_q;
  // last good value already emitted
  logic              last_ok_q;
  logic [DATA_W-1:0] last_data_q;
  // output register
  logic              out_v_q;
  logic [DATA_W-1:0] out_data_q;
  logic              out_subst_q;

  logic              in_lost;
  logic              accept;
  logic              emit;
  logic [DATA_W-1:0] sel_data;
  logic              sel_subst;
  sub_mode_e         mode;

  gap_classify u_classify (
    .present_i  (in_present_i),
    .qual_bad_i (in_qual_bad_i),
    .sync_i     (in_sync_i),
    .lost_o     (in_lost)
  );

  always_comb begin
    mode       = sub_mode_e'(mode_i);
    in_ready_o = !out_v_q || out_ready_i;
    accept     = in_valid_i && in_ready_o;
    emit       = accept && hold_v_q;
  end

  gap_select #(.DATA_W(DATA_W)) u_select (
    .mode_i      (mode),
    .cur_data_i  (hold_data_q),
    .cur_lost_i  (hold_lost_q),
    .prev_data_i (last_data_q),
    .prev_ok_i   (last_ok_q),
    .next_data_i (in_data_i),
    .next_lost_i (in_lost),
    .data_o      (sel_data),
    .subst_o     (sel_subst)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q    <= 1'b0;
      hold_data_q <= '0;
      hold_lost_q <= 1'b0;
    end else if (accept) begin
      hold_v_q    <= 1'b1;
      hold_data_q <= in_data_i;
      hold_lost_q <= in_lost;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_ok_q   <= 1'b0;
      last_data_q <= '0;
    end else if (emit && !hold_lost_q) begin
      last_ok_q   <= 1'b1;
      last_data_q <= hold_data_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q     <= 1'b0;
      out_data_q  <= '0;
      out_subst_q <= 1'b0;
    end else if (emit) begin
      out_v_q     <= 1'b1;
      out_data_q  <= sel_data;
      out_subst_q <= sel_subst;
    end else if (out_ready_i) begin
      out_v_q     <= 1'b0;
    end
  end

  gap_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (emit && sel_subst),
    .cnt_o  (subst_cnt_o)
  );

  assign out_valid_o = out_v_q;
  assign out_data_o  = out_data_q;
  assign out_subst_o = out_subst_q;

  p_stall_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_v_q && !out_ready_i |=> out_v_q && $stable(out_data_q) && $stable(out_subst_q));

  p_first_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !hold_v_q |=> !out_v_q);

  p_good_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit && !hold_lost_q |=> out_data_q == $past(hold_data_q) && !out_subst_q);

  p_zero_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit && hold_lost_q && mode == SUB_ZERO |=> out_data_q == '0 && out_subst_q);

  p_hold_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit && hold_lost_q && mode == SUB_HOLD && last_ok_q
      |=> out_data_q == $past(last_data_q) && out_subst_q);

  p_next_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit && hold_lost_q && mode == SUB_NEXT && in_present_i && !in_qual_bad_i && in_sync_i
      |=> out_data_q == $past(in_data_i));
endmodule

// File: tb/tb_smp_gap_fill.sv
module tb_smp_gap_fill;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CNT_W  = 3;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              in_valid_i = 1'b0;
  logic              in_ready_o;
  logic [DATA_W-1:0] in_data_i = '0;
  logic              in_present_i = 1'b1;
  logic              in_qual_bad_i = 1'b0;
  logic              in_sync_i = 1'b1;
  logic [1:0]        mode_i = 2'd0;
  logic              out_valid_o;
  logic              out_ready_i = 1'b1;
  logic [DATA_W-1:0] out_data_o;
  logic              out_subst_o;
  logic [CNT_W-1:0]  subst_cnt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  smp_gap_fill #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i),
    .in_present_i(in_present_i), .in_qual_bad_i(in_qual_bad_i), .in_sync_i(in_sync_i),
    .mode_i(mode_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
    .out_subst_o(out_subst_o), .subst_cnt_o(subst_cnt_o)
  );

  typedef struct packed {
    logic signed [15:0] d;
    logic               p;
    logic               q;
    logic               s;
    logic [1:0]         m;
    logic               chk;
    logic signed [15:0] ed;
    logic               es;
  } vec_t;

  // each row: input sample, mode at its accept, expected output for the previous sample
  localparam vec_t VECS [18] = '{
    '{16'sd100,  1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 16'sd0,    1'b0},
    '{16'sd200,  1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 16'sd100,  1'b0}, // R4
    '{16'sd50,   1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 16'sd200,  1'b0}, // R1 cause: not present
    '{16'sd300,  1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 16'sd0,    1'b1}, // R1, R5
    '{16'sd400,  1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 16'sd300,  1'b0},
    '{16'sd7,    1'b1, 1'b1, 1'b1, 2'd1, 1'b1, 16'sd400,  1'b0}, // R2 cause: quality bad
    '{16'sd500,  1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 16'sd400,  1'b1}, // R2, R6
    '{16'sd9,    1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 16'sd500,  1'b0}, // R3 cause: not synced
    '{16'sd600,  1'b1, 1'b0, 1'b1, 2'd2, 1'b1, 16'sd600,  1'b1}, // R3, R7 next good
    '{16'sd11,   1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 16'sd600,  1'b0},
    '{16'sd13,   1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 16'sd600,  1'b1}, // R7 fallback
    '{-16'sd200, 1'b1, 1'b0, 1'b1, 2'd3, 1'b1, 16'sd200,  1'b1}, // R8 mean
    '{16'sd5,    1'b0, 1'b0, 1'b1, 2'd3, 1'b1, -16'sd200, 1'b0},
    '{-16'sd101, 1'b1, 1'b0, 1'b1, 2'd3, 1'b1, -16'sd151, 1'b1}, // R8 odd negative sum
    '{16'sd8,    1'b0, 1'b0, 1'b1, 2'd3, 1'b1, -16'sd101, 1'b0},
    '{16'sd8,    1'b0, 1'b0, 1'b1, 2'd3, 1'b1, -16'sd101, 1'b1}, // R8 fallback
    '{16'sd1000, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1, -16'sd101, 1'b1}, // R6
    '{16'sd2,    1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 16'sd1000, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the accept edge
  task automatic send(input logic [15:0] d, input logic p, input logic q,
                      input logic s, input logic [1:0] m);
    in_data_i = d; in_present_i = p; in_qual_bad_i = q; in_sync_i = s;
    mode_i = m; in_valid_i = 1'b1;
    while (!in_ready_o) @(negedge clk);
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid_o == 1'b0, "R12", "out_valid in reset", out_valid_o, 0);
    check(subst_cnt_o == '0,   "R12", "count in reset", subst_cnt_o, 0);
    check(in_ready_o == 1'b1,  "R12", "in_ready in reset", in_ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 18; i++) begin
      string tag;
      send(VECS[i].d, VECS[i].p, VECS[i].q, VECS[i].s, VECS[i].m);
      if (!VECS[i].chk) begin
        check(out_valid_o == 1'b0, "R9", "no output before look-ahead", out_valid_o, 0);
      end else begin
        if (!VECS[i].es) tag = "R4";
        else case (VECS[i-1 < 0 ? 0 : i].m)
          2'd0: tag = "R5";
          2'd1: tag = "R6";
          2'd2: tag = "R7";
          default: tag = "R8";
        endcase
        check(out_valid_o == 1'b1, "R9", $sformatf("vec %0d valid", i), out_valid_o, 1);
        check($signed(out_data_o) == VECS[i].ed, tag, $sformatf("vec %0d data", i),
              $signed(out_data_o), VECS[i].ed);
        check(out_subst_o == VECS[i].es, tag, $sformatf("vec %0d subst flag", i),
              out_subst_o, VECS[i].es);
      end
    end
    // eight substitutions in the table saturate a 3-bit counter
    check(subst_cnt_o == 3'd7, "R11", "count after table", subst_cnt_o, 7);

    // no good value since reset
    do_reset();
    check(out_valid_o == 1'b0, "R12", "out_valid after reset", out_valid_o, 0);
    check(subst_cnt_o == '0,   "R12", "count after reset", subst_cnt_o, 0);
    send(16'd40, 1'b0, 1'b0, 1'b1, 2'd1);
    check(out_valid_o == 1'b0, "R9", "first sample held", out_valid_o, 0);
    send(16'd41, 1'b0, 1'b0, 1'b1, 2'd1);
    check(out_data_o == '0 && out_subst_o, "R6", "no good yet gives zero", out_data_o, 0);
    send(16'd77, 1'b1, 1'b0, 1'b1, 2'd3);
    check(out_data_o == '0 && out_subst_o, "R8", "no previous good gives zero", out_data_o, 0);
    check(subst_cnt_o == 3'd2, "R11", "count increments", subst_cnt_o, 2);

    do_reset();
    send(16'd3, 1'b1, 1'b1, 1'b1, 2'd2);
    send(16'd55, 1'b1, 1'b0, 1'b1, 2'd2);
    check(out_data_o == 16'd55 && out_subst_o, "R7", "next good after reset", out_data_o, 55);

    // output stall
    out_ready_i = 1'b0;
    in_data_i = 16'd10; in_present_i = 1'b1; in_qual_bad_i = 1'b0; in_sync_i = 1'b1;
    mode_i = 2'd0; in_valid_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(in_ready_o == 1'b0, "R10", "in_ready during stall", in_ready_o, 0);
      check(out_valid_o && out_data_o == 16'd55 && out_subst_o, "R10",
            "output held during stall", out_data_o, 55);
    end
    out_ready_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0;
    check(out_valid_o && out_data_o == 16'd55 && !out_subst_o, "R4",
          "held good sample after stall", out_data_o, 55);

    // saturation
    do_reset();
    send(16'd1, 1'b0, 1'b0, 1'b1, 2'd0);
    send(16'd1, 1'b0, 1'b0, 1'b1, 2'd0);
    check(subst_cnt_o == 3'd1, "R11", "count after one substitution", subst_cnt_o, 1);
    for (int k = 0; k < 9; k++) send(16'd1, 1'b0, 1'b0, 1'b1, 2'd0);
    check(subst_cnt_o == 3'd7, "R11", "count saturates", subst_cnt_o, 7);

    finish_run();
  end
endmodule